// File: doc/BRIEF.md
# ASID-tagged fully associative translation cache

This block caches virtual-to-physical page translations for one requester. A lookup presents a 48-bit virtual address, the current address-space tag and an access kind (read, write or execute). In the same cycle it answers with a clean hit, a permission fault or a miss, and on a clean hit it also gives the physical address. Every slot is compared in parallel, and any slot can hold any mapping of either 4 KB or 2 MB size.

Slots are filled by an external table walker through a separate write port, and a flush port can drop translations. Every slot carries an 8-bit address-space tag and a shared flag. A context switch therefore needs no flush: the requester only changes the tag it presents. Shared (kernel) translations answer under every tag and survive a tag-wide flush. Each slot keeps its own permission, referenced and modified bits. The referenced bits steer a second-chance (clock) victim choice when the table is full, and the modified bit is reported on hits so the walker can tell whether the page table entry still needs its modified mark written back.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is empty. While `lk_valid` is low, and for any lookup that matches no slot, `lk_hit`, `lk_fault`, `lk_dirty` and `lk_paddr` are all 0.
- R2: A lookup that matches a 4 KB slot with permission answers in the same cycle with `lk_hit`=1 and `lk_paddr` = {stored frame, `lk_vaddr[11:0]`}.
- R3: A 2 MB slot (`fill_huge`=1) matches every virtual page number whose bits [35:9] equal its own. On a hit, `lk_paddr` = {stored frame bits [27:9], `lk_vaddr[20:0]`}, so the low 9 frame bits written at fill time are ignored.
- R4: A non-shared slot matches only when `lk_asid` equals its stored tag. Changing `lk_asid` removes no slot.
- R5: A slot filled with `fill_global`=1 matches under any `lk_asid`.
- R6: The permission field is bit 0 read, bit 1 write, bit 2 execute. `lk_acc` is 0 read, 1 write, 2 execute, and the value 3 is never allowed. A match whose access is not allowed gives `lk_fault`=1, `lk_hit`=0 and `lk_paddr`=0. When several slots match, the lowest-numbered one answers.
- R7: A write hit sets the slot's modified bit. `lk_dirty` shows the slot's modified bit as stored before the current access, and a fill clears it.
- R8: A fill with no matching slot goes to the lowest-numbered empty slot when one exists, and then evicts nothing.
- R9: A clean hit sets the slot's referenced bit, and a fill writes it clear. When the table is full, the fill scans from the clock pointer (0 after reset). It clears each set referenced bit it passes and takes the first slot found clear; if all are set, it takes the pointer's slot. The pointer then moves one past the victim.
- R10: A fill whose page number and tag would be matched by an existing slot (the same matching rule as a lookup) overwrites the lowest such slot.
- R11: `flush_all` empties every non-shared slot. Shared slots stay.
- R12: `flush_asid_en` empties only the non-shared slots whose tag equals `flush_asid`.
- R13: A lookup answers from the table as it stood before the clock edge. At the edge, updates apply in this order: clock clears, then hit marks, then flushes, then the fill write, so the fill survives a flush in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lk_hit | output | 1 | Clean hit |
| lk_fault | output | 1 | Matching slot forbids the access |
| lk_dirty | output | 1 | Modified bit of the hit slot |
| lk_paddr | output | PA_W | Translated physical address (0 unless hit) |
| fill_valid | input | 1 | Write one translation |
| fill_vpn | input | 36 | Virtual page number of the fill |
| fill_asid | input | 8 | Address-space tag of the fill |
| fill_pfn | input | PA_W-12 | Physical frame number of the fill |
| fill_perm | input | 3 | Permission bits {execute, write, read} |
| fill_global | input | 1 | Fill is shared by all tags |
| fill_huge | input | 1 | Fill is a 2 MB mapping |
| flush_all | input | 1 | Drop all non-shared slots |
| flush_asid_en | input | 1 | Drop non-shared slots of one tag |
| flush_asid | input | 8 | Tag for the selective flush |

## Verification
The lookup port and the fill/flush ports are independent, so a lookup can land in the same cycle as a fill that targets the very slot it hits, or as a flush that removes it. The bench provokes this on purpose: it looks up a page in the cycle it is filled, hits a slot in the cycle the clock evicts it, and fills in the cycle of a flush. It also runs a long mixed stream drawn from a small pool of pages and tags, so collisions are frequent. Each cycle's outputs are judged against a bench-side table model. The model answers from the pre-edge state and then applies clock clears, hit marks, flushes and the fill in the order fixed by R13.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W    = 48;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int HUGE_LO = 9;
    localparam int ASID_W  = 8;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic              glob;
        logic              huge;
        logic [2:0]        perm;
        logic              refd;
        logic              dirty;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
    } tag_t;

    function automatic logic perm_ok(logic [2:0] perm, logic [1:0] acc);
        case (acc)
            ACC_RD:  return perm[0];
            ACC_WR:  return perm[1];
            ACC_EX:  return perm[2];
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tag_t [ENTRIES-1:0] tags,
    input  logic [VPN_W-1:0]   vpn,
    input  logic [ASID_W-1:0]  asid,
    output logic [ENTRIES-1:0] match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic space_ok;
        logic page_ok;
        assign space_ok = tags[g].glob || (tags[g].asid == asid);
        assign page_ok  = tags[g].huge
                        ? (tags[g].vpn[VPN_W-1:HUGE_LO] == vpn[VPN_W-1:HUGE_LO])
                        : (tags[g].vpn == vpn);
        assign match[g] = tags[g].valid && space_ok && page_ok;
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int WIDTH = 16,
    parameter int IW    = 4
) (
    input  logic [WIDTH-1:0] req,
    output logic             found,
    output logic [IW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_clock.sv
module tlb_clock #(
    parameter int ENTRIES = 16,
    parameter int IW      = 4
) (
    input  logic [ENTRIES-1:0] refd,
    input  logic [IW-1:0]      ptr,
    output logic [IW-1:0]      victim,
    output logic [ENTRIES-1:0] clr,
    output logic [IW-1:0]      ptr_next
);
    logic done;

    always_comb begin
        done   = 1'b0;
        victim = ptr;
        clr    = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (!done) begin
                if (refd[(int'(ptr) + k) % ENTRIES]) begin
                    clr[(int'(ptr) + k) % ENTRIES] = 1'b1;
                end else begin
                    victim = IW'((int'(ptr) + k) % ENTRIES);
                    done   = 1'b1;
                end
            end
        end
        ptr_next = (int'(victim) + 1 == ENTRIES) ? '0 : victim + 1'b1;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PA_W    = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [VA_W-1:0]         lk_vaddr,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic [1:0]              lk_acc,
    output logic                    lk_hit,
    output logic                    lk_fault,
    output logic                    lk_dirty,
    output logic [PA_W-1:0]         lk_paddr,
    input  logic                    fill_valid,
    input  logic [VPN_W-1:0]        fill_vpn,
    input  logic [ASID_W-1:0]       fill_asid,
    input  logic [PA_W-OFF_W-1:0]   fill_pfn,
    input  logic [2:0]              fill_perm,
    input  logic                    fill_global,
    input  logic                    fill_huge,
    input  logic                    flush_all,
    input  logic                    flush_asid_en,
    input  logic [ASID_W-1:0]       flush_asid
);
    localparam int PFN_W = PA_W - OFF_W;
    localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tag_t [ENTRIES-1:0] tags;
    logic [PFN_W-1:0]   pfns [ENTRIES];
    logic [IW-1:0]      clk_ptr;

    // lookup path
    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] lk_match;
    logic               lk_found;
    logic [IW-1:0]      lk_idx;
    tag_t               sel_tag;
    logic [PFN_W-1:0]   sel_pfn;
    logic               allow;

    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

    tlb_cam #(.ENTRIES(ENTRIES)) u_lk_cam (
        .tags(tags), .vpn(lk_vpn), .asid(lk_asid), .match(lk_match)
    );
    tlb_pick #(.WIDTH(ENTRIES), .IW(IW)) u_lk_pick (
        .req(lk_match), .found(lk_found), .idx(lk_idx)
    );

    always_comb begin
        sel_tag  = tags[lk_idx];
        sel_pfn  = pfns[lk_idx];
        allow    = perm_ok(sel_tag.perm, lk_acc);
        lk_hit   = lk_valid && lk_found && allow;
        lk_fault = lk_valid && lk_found && !allow;
        lk_dirty = lk_hit && sel_tag.dirty;
        if (!lk_hit) begin
            lk_paddr = '0;
        end else if (sel_tag.huge) begin
            lk_paddr = {sel_pfn[PFN_W-1:HUGE_LO], lk_vaddr[OFF_W+HUGE_LO-1:0]};
        end else begin
            lk_paddr = {sel_pfn, lk_vaddr[OFF_W-1:0]};
        end
    end

    // fill path
    logic [ENTRIES-1:0] fl_match;
    logic [ENTRIES-1:0] empty_vec;
    logic [ENTRIES-1:0] refd_vec;
    logic               dup_found;
    logic [IW-1:0]      dup_idx;
    logic               inv_found;
    logic [IW-1:0]      inv_idx;
    logic [IW-1:0]      victim;
    logic [IW-1:0]      ptr_nxt;
    logic [ENTRIES-1:0] clr_mask;
    logic               use_clock;
    logic [IW-1:0]      fill_slot;
    tag_t               fill_tag;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            empty_vec[i] = !tags[i].valid;
            refd_vec[i]  = tags[i].refd;
        end
    end

    tlb_cam #(.ENTRIES(ENTRIES)) u_fl_cam (
        .tags(tags), .vpn(fill_vpn), .asid(fill_asid), .match(fl_match)
    );
    tlb_pick #(.WIDTH(ENTRIES), .IW(IW)) u_dup_pick (
        .req(fl_match), .found(dup_found), .idx(dup_idx)
    );
    tlb_pick #(.WIDTH(ENTRIES), .IW(IW)) u_inv_pick (
        .req(empty_vec), .found(inv_found), .idx(inv_idx)
    );
    tlb_clock #(.ENTRIES(ENTRIES), .IW(IW)) u_clock (
        .refd(refd_vec), .ptr(clk_ptr), .victim(victim),
        .clr(clr_mask), .ptr_next(ptr_nxt)
    );

    always_comb begin
        use_clock = !dup_found && !inv_found;
        if (dup_found)      fill_slot = dup_idx;
        else if (inv_found) fill_slot = inv_idx;
        else                fill_slot = victim;
        fill_tag.valid = 1'b1;
        fill_tag.glob  = fill_global;
        fill_tag.huge  = fill_huge;
        fill_tag.perm  = fill_perm;
        fill_tag.refd  = 1'b0;
        fill_tag.dirty = 1'b0;
        fill_tag.asid  = fill_asid;
        fill_tag.vpn   = fill_vpn;
    end

    // state update: clock clears, hit marks, flushes, fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tags    <= '0;
            clk_ptr <= '0;
            for (int i = 0; i < ENTRIES; i++) pfns[i] <= '0;
        end else begin
            if (fill_valid && use_clock) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (clr_mask[i]) tags[i].refd <= 1'b0;
                end
                clk_ptr <= ptr_nxt;
            end
            if (lk_hit) begin
                tags[lk_idx].refd <= 1'b1;
                if (lk_acc == ACC_WR) tags[lk_idx].dirty <= 1'b1;
            end
            for (int i = 0; i < ENTRIES; i++) begin
                if (!tags[i].glob &&
                    (flush_all || (flush_asid_en && tags[i].asid == flush_asid))) begin
                    tags[i].valid <= 1'b0;
                end
            end
            if (fill_valid) begin
                tags[fill_slot] <= fill_tag;
                pfns[fill_slot] <= fill_pfn;
            end
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PA_W    = 40,
    parameter int IW      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [OFF_W-1:0]   lk_va_lo,
    input logic [1:0]         lk_acc,
    input logic               lk_hit,
    input logic               lk_fault,
    input logic [OFF_W-1:0]   lk_pa_lo,
    input logic               fill_valid,
    input logic               flush_all,
    input logic               flush_asid_en,
    input tag_t [ENTRIES-1:0] tags,
    input logic [IW-1:0]      lk_idx
);
    logic [ENTRIES-1:0] valid_v;
    logic [ENTRIES-1:0] local_v;
    logic [ENTRIES-1:0] dirty_v;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            valid_v[i] = tags[i].valid;
            local_v[i] = tags[i].valid && !tags[i].glob;
            dirty_v[i] = tags[i].dirty;
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_fault));

    // R6
    single_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_fault}));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa_lo == lk_va_lo));

    // R11
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && !fill_valid) |=> ($countones(local_v) == 0));

    // R7
    write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_acc == 2'd1 && !fill_valid) |=> dirty_v[$past(lk_idx)]);

    // R10
    fill_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_all && !flush_asid_en) |=> ($countones(valid_v) >= $past($countones(valid_v))));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
    .lk_va_lo(lk_vaddr[11:0]), .lk_acc(lk_acc), .lk_hit(lk_hit),
    .lk_fault(lk_fault), .lk_pa_lo(lk_paddr[11:0]), .fill_valid(fill_valid),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .tags(tags), .lk_idx(lk_idx)
);

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;
    import tlb_pkg::*;
    localparam int N     = 16;
    localparam int PA_W  = 40;
    localparam int PFN_W = PA_W - OFF_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n;
    logic               lk_valid;
    logic [47:0]        lk_vaddr;
    logic [7:0]         lk_asid;
    logic [1:0]         lk_acc;
    logic               lk_hit, lk_fault, lk_dirty;
    logic [PA_W-1:0]    lk_paddr;
    logic               fill_valid;
    logic [35:0]        fill_vpn;
    logic [7:0]         fill_asid;
    logic [PFN_W-1:0]   fill_pfn;
    logic [2:0]         fill_perm;
    logic               fill_global, fill_huge;
    logic               flush_all, flush_asid_en;
    logic [7:0]         flush_asid;

    tlb_xlate #(.ENTRIES(N), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_fault(lk_fault),
        .lk_dirty(lk_dirty), .lk_paddr(lk_paddr), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
        .fill_perm(fill_perm), .fill_global(fill_global), .fill_huge(fill_huge),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    int total = 0;
    int bad   = 0;
    bit reported = 1'b0;
    logic [31:0] seed = 32'h1357_9bdf;

    // bench-side table model built from the requirements
    logic             m_v [N];
    logic             m_g [N];
    logic             m_h [N];
    logic [2:0]       m_perm [N];
    logic             m_ref [N];
    logic             m_dirty [N];
    logic [7:0]       m_asid [N];
    logic [35:0]      m_vpn [N];
    logic [PFN_W-1:0] m_pfn [N];
    int               m_ptr;

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic int m_find(logic [35:0] vpn, logic [7:0] asid);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && (m_g[i] || m_asid[i] == asid) &&
                (m_h[i] ? (vpn[35:9] == m_vpn[i][35:9]) : (vpn == m_vpn[i])))
                return i;
        end
        return -1;
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
    endtask

    task automatic quiet();
        lk_valid = 0; fill_valid = 0; flush_all = 0; flush_asid_en = 0;
    endtask

    task automatic look(logic [47:0] va, logic [7:0] asid, logic [1:0] acc);
        lk_valid = 1; lk_vaddr = va; lk_asid = asid; lk_acc = acc;
    endtask

    task automatic fill(logic [35:0] vpn, logic [7:0] asid, logic [PFN_W-1:0] pfn,
                        logic [2:0] perm, logic glob, logic huge);
        fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        fill_perm = perm; fill_global = glob; fill_huge = huge;
    endtask

    // one clock cycle: check outputs against the model, then advance the model
    task automatic cyc(input string tag);
        int idx, dup, inv, vic;
        logic allow, e_hit, e_fault, e_dirty;
        logic [PA_W-1:0] e_pa;
        #1;
        idx = m_find(lk_vaddr[47:12], lk_asid);
        allow = 1'b0;
        if (idx >= 0) begin
            case (lk_acc)
                2'd0: allow = m_perm[idx][0];
                2'd1: allow = m_perm[idx][1];
                2'd2: allow = m_perm[idx][2];
                default: allow = 1'b0;
            endcase
        end
        e_hit   = lk_valid && idx >= 0 && allow;
        e_fault = lk_valid && idx >= 0 && !allow;
        e_dirty = e_hit && m_dirty[idx];
        e_pa    = '0;
        if (e_hit) e_pa = m_h[idx] ? {m_pfn[idx][PFN_W-1:9], lk_vaddr[20:0]}
                                   : {m_pfn[idx], lk_vaddr[11:0]};
        total++;
        if ({lk_hit, lk_fault, lk_dirty, lk_paddr} !== {e_hit, e_fault, e_dirty, e_pa}) begin
            bad++;
            $display("FAIL %s: hit/fault/dirty/pa got %b %b %b %h exp %b %b %b %h",
                     tag, lk_hit, lk_fault, lk_dirty, lk_paddr, e_hit, e_fault, e_dirty, e_pa);
        end
        dup = fill_valid ? m_find(fill_vpn, fill_asid) : -1;
        inv = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) inv = i;
        @(posedge clk);
        vic = -1;
        if (fill_valid && dup < 0 && inv < 0) begin
            for (int k = 0; k < N; k++) begin
                if (vic < 0) begin
                    if (m_ref[(m_ptr + k) % N]) m_ref[(m_ptr + k) % N] = 1'b0;
                    else vic = (m_ptr + k) % N;
                end
            end
            if (vic < 0) vic = m_ptr;
            m_ptr = (vic + 1) % N;
        end
        if (e_hit) begin
            m_ref[idx] = 1'b1;
            if (lk_acc == 2'd1) m_dirty[idx] = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            if (!m_g[i] && (flush_all || (flush_asid_en && m_asid[i] == flush_asid)))
                m_v[i] = 1'b0;
        end
        if (fill_valid) begin
            if (dup >= 0) vic = dup;
            else if (inv >= 0) vic = inv;
            m_v[vic] = 1; m_g[vic] = fill_global; m_h[vic] = fill_huge;
            m_perm[vic] = fill_perm; m_ref[vic] = 0; m_dirty[vic] = 0;
            m_asid[vic] = fill_asid; m_vpn[vic] = fill_vpn; m_pfn[vic] = fill_pfn;
        end
        @(negedge clk);
        quiet();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R13: got no completion exp completion");
        report();
        $finish;
    end

    initial begin
        rst_n = 0; quiet();
        lk_vaddr = '0; lk_asid = '0; lk_acc = '0;
        fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_perm = '0;
        fill_global = 0; fill_huge = 0; flush_asid = '0;
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_g[i] = 0; m_h[i] = 0; m_perm[i] = 0; m_ref[i] = 0;
            m_dirty[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0;
        end
        m_ptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: empty table after reset, idle port quiet
        for (int k = 0; k < 8; k++) begin
            look(48'(64'h1234_5678_9ABC * k), 8'(k), 2'(k));
            cyc("R1");
        end
        cyc("R1");

        // R8: sixteen fills into an empty table
        for (int i = 0; i < N; i++) begin
            fill(36'h00ABC00 + 36'(i * 5), (i % 2) ? 8'd2 : 8'd1,
                 28'h0F00000 + 28'(i * 'h111), 3'b111, 0, 0);
            cyc("R8");
        end
        // R2: each 4 KB page translates
        for (int i = 0; i < N; i++) begin
            look({36'h00ABC00 + 36'(i * 5), 12'(i * 'hF1)}, (i % 2) ? 8'd2 : 8'd1, 2'd0);
            cyc("R2");
        end
        // R4: other tag misses, nothing removed
        for (int i = 0; i < N; i++) begin
            look({36'h00ABC00 + 36'(i * 5), 12'h3}, (i % 2) ? 8'd1 : 8'd2, 2'd0);
            cyc("R4");
        end
        // R9: clock replacement on a full table
        for (int j = 0; j < 6; j++) begin
            look({36'h00ABC00 + 36'((2 * j + 1) * 5), 12'h0}, 8'd2, 2'd0);
            cyc("R9");
            fill(36'h00DD000 + 36'(j), 8'd1, 28'h0AA0000 + 28'(j), 3'b011, 0, 0);
            cyc("R9");
        end
        for (int i = 0; i < N; i++) begin
            look({36'h00ABC00 + 36'(i * 5), 12'h7}, (i % 2) ? 8'd2 : 8'd1, 2'd0);
            cyc("R9");
        end
        for (int j = 0; j < 6; j++) begin
            look({36'h00DD000 + 36'(j), 12'h9}, 8'd1, 2'd0);
            cyc("R9");
        end

        // R5: shared slot under all 256 tags
        fill(36'h0777777, 8'd5, 28'h0123456, 3'b111, 1, 0);
        cyc("R5");
        for (int a = 0; a < 256; a++) begin
            look({36'h0777777, 12'(a * 13)}, 8'(a), 2'(a % 3));
            cyc("R5");
        end

        // R3: 2 MB slot, all 512 pages plus both neighbours
        fill(36'h0123400, 8'd7, 28'h0ABCDE1, 3'b101, 0, 1);
        cyc("R3");
        for (int k = -1; k <= 512; k++) begin
            look({36'h0123400 + 36'(k), 12'(k * 7)}, 8'd7, 2'd0);
            cyc("R3");
        end
        look({36'h0123455, 12'h0}, 8'd7, 2'd1);
        cyc("R6");

        // R6: every permission against every access kind
        for (int p = 0; p < 8; p++) begin
            fill(36'h0E00000 + 36'(p), 8'd4, 28'h0C00000 + 28'(p), 3'(p), 0, 0);
            cyc("R6");
        end
        for (int p = 0; p < 8; p++) begin
            for (int a = 0; a < 4; a++) begin
                look({36'h0E00000 + 36'(p), 12'h5A5}, 8'd4, 2'(a));
                cyc("R6");
            end
        end

        // R7: modified bit
        look({36'h0E00007, 12'h0}, 8'd4, 2'd1); cyc("R7");
        look({36'h0E00007, 12'h0}, 8'd4, 2'd0); cyc("R7");
        look({36'h0E00002, 12'h0}, 8'd4, 2'd1); cyc("R7");
        look({36'h0E00002, 12'h0}, 8'd4, 2'd2); cyc("R7");

        // R10: refill of a present page overwrites in place
        fill(36'h0E00007, 8'd4, 28'h0D0D0D0, 3'b111, 0, 0);
        cyc("R10");
        look({36'h0E00007, 12'h0}, 8'd4, 2'd0); cyc("R10");
        for (int p = 0; p < 8; p++) begin
            look({36'h0E00000 + 36'(p), 12'h1}, 8'd4, 2'd0);
            cyc("R10");
        end

        // R12: flush one tag
        flush_asid_en = 1; flush_asid = 8'd4;
        cyc("R12");
        for (int p = 0; p < 8; p++) begin
            look({36'h0E00000 + 36'(p), 12'h1}, 8'd4, 2'd0);
            cyc("R12");
        end
        look({36'h0123401, 12'h0}, 8'd7, 2'd0); cyc("R12");
        look({36'h0777777, 12'h0}, 8'd4, 2'd0); cyc("R12");

        // R11: flush everything but shared slots
        flush_all = 1;
        cyc("R11");
        look({36'h0123401, 12'h0}, 8'd7, 2'd0); cyc("R11");
        look({36'h0777777, 12'h0}, 8'd9, 2'd0); cyc("R11");
        look({36'h00DD000, 12'h0}, 8'd1, 2'd0); cyc("R11");

        // R13: same-cycle cases
        fill(36'h0F00001, 8'd1, 28'h0111111, 3'b111, 0, 0);
        look({36'h0F00001, 12'h0}, 8'd1, 2'd0);
        cyc("R13");
        look({36'h0F00001, 12'h0}, 8'd1, 2'd0); cyc("R13");
        flush_all = 1;
        fill(36'h0F00002, 8'd1, 28'h0222222, 3'b111, 0, 0);
        cyc("R13");
        look({36'h0F00002, 12'h0}, 8'd1, 2'd0); cyc("R13");
        look({36'h0F00001, 12'h0}, 8'd1, 2'd0); cyc("R13");

        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r1, r2;
            r1 = rnd();
            r2 = rnd();
            if (r1[0]) look({36'({r1[5:4], 9'(r1[7:6])}), r1[19:8]}, 8'(r1[21:20]), r1[23:22]);
            if (r2[1:0] != 0)
                fill(36'({r2[5:4], 9'(r2[7:6])}), 8'(r2[9:8]), 28'(r2[31:10]),
                     r2[12:10], r2[13] & r2[14], r2[15]);
            if (r2[20:16] == 0) flush_all = 1;
            if (r2[25:21] == 0) begin flush_asid_en = 1; flush_asid = 8'(r2[27:26]); end
            cyc("R13");
        end

        report();
        $finish;
    end
endmodule